// File: doc/BRIEF.md
# EEPROM Page Write Controller

This block sits behind a two-wire serial protocol engine and handles the write path of a 512-byte memory. The engine loads the starting word address of a transfer and then presents each received data byte with a one-cycle strobe. The controller stores each accepted byte in a 16-entry page buffer. Only the low four address bits advance, so a transfer longer than a page wraps and overwrites bytes buffered earlier. For every strobed byte the controller returns an acknowledge decision that the engine drives onto the bus.

When the engine reports a valid stop after a transfer that carried at least one accepted byte, the controller enters a self-timed program cycle. The length of that cycle is a parameter counted in system clocks. At the end of the cycle the buffered bytes are copied into the register array in a single step. A per-byte valid mask limits the update to the locations that were actually received.

While the program cycle runs, the busy output tells the engine to ignore the bus and withhold the slave-address acknowledge. A write-protect input guards the upper half of the array. Address phases are still acknowledged, but data bytes aimed at that half are refused and no program cycle follows. A registered read port gives the engine, and the bench, access to the array contents.

Top module: `eeprom_page_writer`

## Requirements
- R1: After reset, `busy_o` and `ack_vld_o` are 0, `addr_o` is 0 and every array location reads 0.
- R2: A strobed byte that is accepted gives `ack_vld_o`=1 and `ack_o`=1 in the next cycle. In that same cycle, `addr_o[3:0]` has advanced by one modulo 16 and `addr_o[8:4]` is unchanged.
- R3: When a transfer carries more than 16 bytes, the address wraps within the page. A later byte replaces the earlier byte buffered at the same location, and only the last value written to each location is committed.
- R4: `busy_o` rises in the cycle after a stop is presented, and only when the transfer has at least one accepted byte and no refused byte. It then stays high for exactly `PROG_CYCLES` cycles.
- R5: A stop after a transfer with no data bytes starts no program cycle and leaves the array unchanged.
- R6: A commit changes only the locations in the page that received bytes. All other locations keep their contents. The new values are readable from the cycle in which `busy_o` falls.
- R7: With `wp_i`=1 and address bit 8 of the current address equal to 1, a strobed byte gives `ack_vld_o`=1 with `ack_o`=0. Every later byte of that transfer is also refused. The stop then starts no program cycle, and the array is unchanged.
- R8: Bytes aimed at the lower half (address bit 8 = 0) are accepted and committed whatever `wp_i` is. With `wp_i`=0, bytes aimed at the upper half are also accepted and committed.
- R9: While `busy_o` is high, address loads, byte strobes and stops are ignored: `ack_vld_o` stays 0, `addr_o` holds, and the pending commit is unaffected.
- R10: After a commit, `addr_o` points one past the last byte written, wrapping within the page.
- R11: `rd_data_o` shows the array byte at `rd_addr_i` one cycle after the address is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| wp_i | input | 1 | Write protect for the upper half of the array |
| load_i | input | 1 | Load the start address of a new write transfer |
| start_addr_i | input | ADDR_W | Start word address loaded by `load_i` |
| byte_stb_i | input | 1 | One-cycle strobe for a received data byte |
| byte_i | input | 8 | Data byte qualified by `byte_stb_i` |
| stop_i | input | 1 | One-cycle pulse for a valid stop condition |
| rd_addr_i | input | ADDR_W | Read address |
| rd_data_o | output | 8 | Registered read data |
| busy_o | output | 1 | Program cycle in progress; bus interface disabled |
| ack_vld_o | output | 1 | An acknowledge decision is valid this cycle |
| ack_o | output | 1 | 1 = acknowledge the byte, 0 = refuse it |
| addr_o | output | ADDR_W | Shared address counter |

## Verification
Two internal errors show at the ports quickly. A corrupted address counter or page-wrap error appears on `addr_o` one cycle after the byte strobe. A wrong protect decision appears on `ack_o` in that same cycle.

Errors in the valid mask or the page buffer stay hidden until the commit. They become visible only when the affected page is read back after `busy_o` falls. For that reason, the bench reads back the neighbours of every written page as well as the written locations.

A miscounted program timer shows as a wrong `busy_o` width, measured at the cycle `busy_o` falls. A missing busy lock shows as a stray `ack_vld_o` or an `addr_o` change during the cycle.

// File: rtl/eeprom_page_writer.sv
module eeprom_page_writer #(
  parameter int ADDR_W      = 9,
  parameter int PAGE_W      = 4,
  parameter int PROG_CYCLES = 1000000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wp_i,
  input  logic              load_i,
  input  logic [ADDR_W-1:0] start_addr_i,
  input  logic              byte_stb_i,
  input  logic [7:0]        byte_i,
  input  logic              stop_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [7:0]        rd_data_o,
  output logic              busy_o,
  output logic              ack_vld_o,
  output logic              ack_o,
  output logic [ADDR_W-1:0] addr_o
);
  localparam int DEPTH      = 1 << ADDR_W;
  localparam int PAGE_BYTES = 1 << PAGE_W;
  localparam int CNT_W      = $clog2(PROG_CYCLES + 1);

  logic                  busy_q, refused_q, ack_vld_q, ack_q;
  logic [CNT_W-1:0]      cnt_q;
  logic [ADDR_W-1:0]     addr_q;
  logic [PAGE_BYTES-1:0] mask_q;
  logic [7:0]            pbuf_q [PAGE_BYTES];
  logic [7:0]            mem_q  [DEPTH];
  logic [7:0]            rd_q;

  wire idle      = !busy_q;
  wire take_load = idle & load_i;
  wire take_byte = idle & byte_stb_i & !load_i;
  wire take_stop = idle & stop_i & !load_i & !byte_stb_i;
  wire protect   = wp_i & addr_q[ADDR_W-1];
  wire accept    = take_byte & !protect & !refused_q;
  wire launch    = take_stop & (|mask_q) & !refused_q;
  wire done      = busy_q & (cnt_q == '0);
  wire [PAGE_W-1:0] slot = addr_q[PAGE_W-1:0];

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      busy_q    <= 1'b0;
      refused_q <= 1'b0;
      ack_vld_q <= 1'b0;
      ack_q     <= 1'b0;
      cnt_q     <= '0;
      addr_q    <= '0;
      mask_q    <= '0;
    end else begin
      ack_vld_q <= take_byte;
      ack_q     <= accept;
      if (take_load) begin
        addr_q    <= start_addr_i;
        mask_q    <= '0;
        refused_q <= 1'b0;
      end else if (take_byte) begin
        if (accept) begin
          addr_q[PAGE_W-1:0] <= slot + PAGE_W'(1);
          mask_q[slot]       <= 1'b1;
        end else begin
          refused_q <= 1'b1;
        end
      end else if (take_stop) begin
        if (launch) begin
          busy_q <= 1'b1;
          cnt_q  <= CNT_W'(PROG_CYCLES - 1);
        end else begin
          mask_q    <= '0;
          refused_q <= 1'b0;
        end
      end
      if (busy_q) begin
        if (done) begin
          busy_q <= 1'b0;
          mask_q <= '0;
        end else begin
          cnt_q <= cnt_q - CNT_W'(1);
        end
      end
    end
  end

  always_ff @(posedge clk_i) begin
    if (accept) pbuf_q[slot] <= byte_i;
  end

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
      rd_q <= '0;
    end else begin
      if (done) begin
        for (int p = 0; p < PAGE_BYTES; p++)
          if (mask_q[p]) mem_q[{addr_q[ADDR_W-1:PAGE_W], PAGE_W'(p)}] <= pbuf_q[p];
      end
      rd_q <= mem_q[rd_addr_i];
    end
  end

  assign busy_o    = busy_q;
  assign ack_vld_o = ack_vld_q;
  assign ack_o     = ack_q;
  assign addr_o    = addr_q;
  assign rd_data_o = rd_q;
endmodule

// File: rtl/page_wr_ctrl_chk.sv
module page_wr_ctrl_chk #(
  parameter int ADDR_W      = 9,
  parameter int PAGE_W      = 4,
  parameter int PROG_CYCLES = 1000000
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              wp_i,
  input logic              byte_stb_i,
  input logic              stop_i,
  input logic              busy_o,
  input logic              ack_vld_o,
  input logic              ack_o,
  input logic [ADDR_W-1:0] addr_o
);
  logic [31:0] run_q;
  always_ff @(posedge clk_i) begin
    if (!rst_ni)      run_q <= '0;
    else if (!busy_o) run_q <= '0;
    else              run_q <= run_q + 32'd1;
  end

  // R4
  busy_after_stop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(stop_i));
  // R4
  busy_len_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> run_q == 32'(PROG_CYCLES));
  // R2
  ack_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_vld_o |-> $past(byte_stb_i) && !$past(busy_o));
  // R2
  ack_qual_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_o |-> ack_vld_o);
  // R2
  page_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_vld_o |-> addr_o[ADDR_W-1:PAGE_W] == $past(addr_o[ADDR_W-1:PAGE_W]));
  // R7
  wp_nack_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_vld_o && $past(wp_i) && $past(addr_o[ADDR_W-1]) |-> !ack_o);
  // R9
  busy_addr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && $past(busy_o) |-> $stable(addr_o) && !ack_vld_o);
endmodule

bind eeprom_page_writer page_wr_ctrl_chk #(
  .ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .PROG_CYCLES(PROG_CYCLES)
) chk_i (
  .clk_i(clk_i), .rst_ni(rst_ni), .wp_i(wp_i), .byte_stb_i(byte_stb_i),
  .stop_i(stop_i), .busy_o(busy_o), .ack_vld_o(ack_vld_o), .ack_o(ack_o),
  .addr_o(addr_o)
);

// File: tb/eeprom_page_writer_tb_top.sv
`timescale 1ns/1ps
module eeprom_page_writer_tb_top;
  localparam int AW = 9;
  localparam int PROG = 37;

  logic clk = 0, rst_n = 0;
  logic wp = 0, load = 0, stb = 0, stop = 0;
  logic [AW-1:0] saddr = '0, raddr = '0;
  logic [7:0] bdat = '0, rdata;
  logic busy, ackv, ack;
  logic [AW-1:0] addr;

  int checks = 0, errors = 0;
  logic [7:0] model [512];

  always #2.5 clk = ~clk;

  eeprom_page_writer #(.ADDR_W(AW), .PAGE_W(4), .PROG_CYCLES(PROG)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .wp_i(wp), .load_i(load), .start_addr_i(saddr),
    .byte_stb_i(stb), .byte_i(bdat), .stop_i(stop), .rd_addr_i(raddr),
    .rd_data_o(rdata), .busy_o(busy), .ack_vld_o(ackv), .ack_o(ack), .addr_o(addr));

  task automatic tick;
    @(posedge clk); @(negedge clk);
  endtask

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic logic [AW-1:0] next_in_page(input logic [AW-1:0] a);
    return {a[AW-1:4], a[3:0] + 4'd1};
  endfunction

  task automatic rd_chk(input logic [AW-1:0] a, input string req);
    raddr = a; tick;
    chk(rdata == model[a], req, rdata, model[a]);
  endtask

  task automatic page_chk(input logic [AW-1:0] a, input string req);
    for (int i = 0; i < 16; i++) rd_chk({a[AW-1:4], 4'(i)}, req);
  endtask

  // one write transfer: load, n bytes, stop, optional poke while busy
  task automatic xfer(input logic [AW-1:0] start, input int n, input bit wpv, input bit poke);
    logic [AW-1:0] a;
    logic [7:0] pb [16];
    bit msk [16];
    bit refm;
    bit exp_acc;
    int cnt;
    a = start; refm = 0;
    for (int i = 0; i < 16; i++) msk[i] = 0;
    load = 1; saddr = start; tick; load = 0;
    chk(addr == start, "R2", addr, start);
    for (int i = 0; i < n; i++) begin
      stb = 1; wp = wpv; bdat = 8'($urandom); tick; stb = 0;
      exp_acc = !(wpv && a[AW-1]) && !refm;
      chk(ackv == 1, "R2", ackv, 1);
      chk(ack == exp_acc, wpv && a[AW-1] ? "R7" : "R8", ack, exp_acc);
      if (exp_acc) begin
        pb[a[3:0]] = bdat; msk[a[3:0]] = 1; a = next_in_page(a);
      end else refm = 1;
      chk(addr == a, n > 16 ? "R3" : "R2", addr, a);
    end
    stop = 1; tick; stop = 0;
    begin
      bit any = 0;
      for (int i = 0; i < 16; i++) any |= msk[i];
      chk(busy == (any && !refm), n == 0 ? "R5" : (refm ? "R7" : "R4"), busy, any && !refm);
      if (any && !refm) begin
        cnt = 1;
        if (poke) begin
          load = 1; saddr = ~start; stb = 1; stop = 1; tick;
          load = 0; stb = 0; stop = 0;
          cnt += busy;
          chk(ackv == 0, "R9", ackv, 0);
          chk(addr == a, "R9", addr, a);
        end
        while (busy) begin tick; if (busy) cnt++; end
        chk(cnt == PROG, "R4", cnt, PROG);
        for (int i = 0; i < 16; i++)
          if (msk[i]) model[{a[AW-1:4], 4'(i)}] = pb[i];
        chk(addr == a, "R10", addr, a);
      end
    end
    page_chk(start, "R6");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd24681));
    for (int i = 0; i < 512; i++) model[i] = 8'h00;
    repeat (3) tick;
    rst_n = 1; tick;
    // R1
    chk(busy == 0, "R1", busy, 0);
    chk(ackv == 0, "R1", ackv, 0);
    chk(addr == 0, "R1", addr, 0);
    rd_chk(9'd5, "R1");
    rd_chk(9'd511, "R11");
    // directed corners
    xfer(9'h023, 1, 1, 0);   // R8 lower half under protect
    xfer(9'h07A, 20, 0, 0);  // R3 wrap and overwrite
    xfer(9'h040, 0, 0, 0);   // R5 empty transfer
    xfer(9'h1C4, 3, 1, 0);   // R7 protected upper half
    xfer(9'h1C4, 5, 0, 1);   // R8 upper half unprotected, R9 poke
    xfer(9'h10F, 16, 0, 0);  // full page starting at slot 15
    for (int k = 0; k < 30; k++)
      xfer(9'($urandom), int'($urandom % 21), bit'($urandom % 3 == 0), bit'($urandom & 1));
    for (int i = 0; i < 512; i++) rd_chk(9'(i), "R11");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule